// File: doc/BRIEF.md
# Deferred-Retire Column Write Buffer

This block sits between the column-command decoder of a banked memory device and its row buffers. A column write aimed at this device does not reach the row buffer straight away. The block parks the 16-byte data unit in a single-entry buffer, together with its bank address, its column address (one of 64 column units) and an optional byte mask. The parked write is committed, or retired, during a later column-operation slot. This frees the internal data path from having to turn around between the write and the next command.

Each column slot presents one decoded command (no-op, read or write) and a flag that says whether the command targets this device. The retire point depends on that command:

- A read aimed at this device never shares its slot with a retire.
- Every other command slot retires a pending entry.

A read to this device that hits the parked bank and column is served with the parked bytes laid over the core data. Software never sees stale data for that reason. The row buffer storage itself lives outside the block.

Top module: `wbuf_top`

## Requirements
- R1: A slot with `cmdValid`=1, `cmdOp`=2'b10 (write) and `sameDev`=1 stores `cmdBank`, `cmdCol` and `wrData` in the buffer. When the buffer was empty, no retire happens in that slot.
- R2: A slot with `cmdOp`=2'b00 (no-op) and `sameDev`=1 retires a pending entry. In the cycle after that slot's clock edge, `retireValid` is 1 and `retireBank`, `retireCol` and `retireData` carry the stored values.
- R3: A read (2'b01), write or no-op slot with `sameDev`=0 retires a pending entry. A write with `sameDev`=0 does not load the buffer.
- R4: A read slot with `sameDev`=1 never retires. The entry stays pending and retires at the next slot that allows it.
- R5: `retireMask` bit b enables byte b (`retireData[8b+7:8b]`). It equals the stored `wrMask` when `maskEn` was 1 with the write, and 16'hFFFF otherwise.
- R6: A write to this device while an entry is pending retires the old entry in that slot and loads the new one.
- R7: One cycle after a read slot with `sameDev`=1, `rdValid` is 1. `rdData` takes byte b from the pending entry when the entry matches bank and column and its mask bit b is set. Every other byte comes from `coreRdData`.
- R8: Reset empties the buffer and issues no retire, so a later slot retires nothing.
- R9: After a retire the buffer is empty, and a further slot issues no second retire.
- R10: Cycles with `cmdValid`=0 never retire and leave the entry pending, whatever `cmdOp` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column slot clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A column command is present in this slot |
| cmdOp | input | 2 | 00 no-op, 01 read, 10 write, 11 treated as no-op |
| sameDev | input | 1 | Command targets this device |
| cmdBank | input | 5 | Bank address of the command |
| cmdCol | input | 6 | Column unit address of the command |
| wrData | input | 128 | Write data unit |
| wrMask | input | 16 | Byte enables for the write |
| maskEn | input | 1 | The write carries a byte mask |
| coreRdData | input | 128 | Data read from the row buffer for this slot |
| retireValid | output | 1 | Retire strobe toward the row buffer |
| retireBank | output | 5 | Bank of the retired write |
| retireCol | output | 6 | Column of the retired write |
| retireData | output | 128 | Data of the retired write |
| retireMask | output | 16 | Byte enables of the retired write |
| rdValid | output | 1 | Read data for a same-device read is valid |
| rdData | output | 128 | Read data merged with the pending write |

## Verification
Writes are followed by each kind of slot that may retire: a no-op to this device, and a read, write or no-op to another device. Each must produce one retire carrying the parked address and data. A foreign write must also leave nothing behind to retire later. Same-device reads are tried both with a matching and with a non-matching address, and with a full and with a partial byte mask. These cases separate a retire that is held back from one that is missing, and a merge that honours the mask from one that ignores it. Back-to-back writes, idle cycles carrying a write opcode, and a reset with an entry pending show that the entry is replaced, kept or discarded at exactly the intended point.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_RSV = 2'b11
  } colOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture incoming write
    logic retire;    // commit pending entry
    logic rdOut;     // same-device read leaves the block next cycle
    logic mergeHit;  // read hits the pending entry
  } wbufStrbS;
endpackage

// File: rtl/wbuf_ctrl.sv
`timescale 1ns/1ps
module wbuf_ctrl
  import wbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmdValid,
  input  colOpE    cmdOp,
  input  logic     sameDev,
  input  logic     addrMatch,
  output wbufStrbS strb,
  output logic     bufFull
);
  logic isRd;
  logic isWr;

  assign isRd = cmdValid && (cmdOp == OP_RD);
  assign isWr = cmdValid && (cmdOp == OP_WR);

  always_comb begin
    strb.load     = isWr && sameDev;
    // a same-device read blocks the retire; every other slot allows it
    strb.retire   = bufFull && cmdValid && !(isRd && sameDev);
    strb.rdOut    = isRd && sameDev;
    strb.mergeHit = isRd && sameDev && bufFull && addrMatch;
  end

  always_ff @(posedge clk) begin
    if (rst)            bufFull <= 1'b0;
    else if (strb.load) bufFull <= 1'b1;
    else if (strb.retire) bufFull <= 1'b0;
  end
endmodule

// File: rtl/wbuf_datapath.sv
`timescale 1ns/1ps
module wbuf_datapath
  import wbuf_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int BYTES  = 16,
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wbufStrbS          strb,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  wrMask,
  input  logic              maskEn,
  input  logic [DATA_W-1:0] coreRdData,
  output logic              addrMatch,
  output logic              retireValid,
  output logic [BANK_W-1:0] retireBank,
  output logic [COL_W-1:0]  retireCol,
  output logic [DATA_W-1:0] retireData,
  output logic [BYTES-1:0]  retireMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [BANK_W-1:0] entBank;
  logic [COL_W-1:0]  entCol;
  logic [DATA_W-1:0] entData;
  logic [BYTES-1:0]  entMask;
  logic [DATA_W-1:0] mergedData;

  assign addrMatch = (entBank == cmdBank) && (entCol == cmdCol);

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign mergedData[b*8 +: 8] = (strb.mergeHit && entMask[b])
                                  ? entData[b*8 +: 8]
                                  : coreRdData[b*8 +: 8];
  end

  // entry payload: no reset needed, qualified by the control's full flag
  always_ff @(posedge clk) begin
    if (strb.load) begin
      entBank <= cmdBank;
      entCol  <= cmdCol;
      entData <= wrData;
      entMask <= maskEn ? wrMask : '1;
    end
    if (strb.retire) begin
      retireBank <= entBank;
      retireCol  <= entCol;
      retireData <= entData;
      retireMask <= entMask;
    end
    if (strb.rdOut) rdData <= mergedData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      retireValid <= 1'b0;
      rdValid     <= 1'b0;
    end else begin
      retireValid <= strb.retire;
      rdValid     <= strb.rdOut;
    end
  end
endmodule

// File: rtl/wbuf_top.sv
`timescale 1ns/1ps
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int BYTES  = 16,
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              sameDev,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  wrMask,
  input  logic              maskEn,
  input  logic [DATA_W-1:0] coreRdData,
  output logic              retireValid,
  output logic [BANK_W-1:0] retireBank,
  output logic [COL_W-1:0]  retireCol,
  output logic [DATA_W-1:0] retireData,
  output logic [BYTES-1:0]  retireMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  wbufStrbS strb;
  logic     bufFull;
  logic     addrMatch;

  wbuf_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdOp    (colOpE'(cmdOp)),
    .sameDev  (sameDev),
    .addrMatch(addrMatch),
    .strb     (strb),
    .bufFull  (bufFull)
  );

  wbuf_datapath #(.BANK_W(BANK_W), .COL_W(COL_W), .BYTES(BYTES)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .cmdBank    (cmdBank),
    .cmdCol     (cmdCol),
    .wrData     (wrData),
    .wrMask     (wrMask),
    .maskEn     (maskEn),
    .coreRdData (coreRdData),
    .addrMatch  (addrMatch),
    .retireValid(retireValid),
    .retireBank (retireBank),
    .retireCol  (retireCol),
    .retireData (retireData),
    .retireMask (retireMask),
    .rdValid    (rdValid),
    .rdData     (rdData)
  );
endmodule

// File: rtl/wbuf_chk.sv
`timescale 1ns/1ps
module wbuf_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       sameDev,
  input logic       bufFull,
  input logic       retireValid,
  input logic       rdValid
);
  // R4
  no_retire_on_own_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'b01 && sameDev) |=> !retireValid);

  // R2
  retire_when_allowed_chk: assert property (@(posedge clk) disable iff (rst)
    (bufFull && cmdValid && !(cmdOp == 2'b01 && sameDev)) |=> retireValid);

  // R9
  retire_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    !bufFull |=> !retireValid);

  // R10
  idle_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> !retireValid);

  // R7
  read_out_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'b01 && sameDev) |=> rdValid);

  // R6
  full_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'b10 && sameDev) |=> bufFull);
endmodule

bind wbuf_top wbuf_chk i_wbuf_chk (
  .clk        (clk),
  .rst        (rst),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .sameDev    (sameDev),
  .bufFull    (bufFull),
  .retireValid(retireValid),
  .rdValid    (rdValid)
);

// File: tb/test_wbuf_top.sv
`timescale 1ns/1ps
module test_wbuf_top;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmdValid = 1'b0;
  logic [1:0]   cmdOp = NOP;
  logic         sameDev = 1'b0;
  logic [4:0]   cmdBank = '0;
  logic [5:0]   cmdCol = '0;
  logic [127:0] wrData = '0;
  logic [15:0]  wrMask = '0;
  logic         maskEn = 1'b0;
  logic [127:0] coreRdData = '0;
  logic         retireValid;
  logic [4:0]   retireBank;
  logic [5:0]   retireCol;
  logic [127:0] retireData;
  logic [15:0]  retireMask;
  logic         rdValid;
  logic [127:0] rdData;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  wbuf_top i_wbuf_top (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .sameDev(sameDev),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .wrData(wrData), .wrMask(wrMask),
    .maskEn(maskEn), .coreRdData(coreRdData), .retireValid(retireValid),
    .retireBank(retireBank), .retireCol(retireCol), .retireData(retireData),
    .retireMask(retireMask), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(seed * 17 + i * 29 + 3);
    return v;
  endfunction

  // one column slot; outputs sampled just after the capturing edge
  task automatic slot(input logic [1:0] op, input logic same, input logic [4:0] bank,
                      input logic [5:0] col, input logic [127:0] data,
                      input logic [15:0] mask, input logic men, input logic [127:0] core);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; sameDev = same; cmdBank = bank; cmdCol = col;
    wrData = data; wrMask = mask; maskEn = men; coreRdData = core;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = WR; sameDev = 1'b1; wrData = pat(99);
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; cmdValid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic expRetire(input string req, input logic [4:0] bank, input logic [5:0] col,
                           input logic [127:0] data, input logic [15:0] mask);
    chk({req, " retireValid"}, 128'(retireValid), 128'(1'b1));
    chk({req, " retireBank"}, 128'(retireBank), 128'(bank));
    chk({req, " retireCol"}, 128'(retireCol), 128'(col));
    chk({req, " retireData"}, retireData, data);
    chk({req, " retireMask"}, 128'(retireMask), 128'(mask));
  endtask

  task automatic expNoRetire(input string req);
    chk({req, " no retire"}, 128'(retireValid), 128'(1'b0));
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    chk("R8 reset retireValid", 128'(retireValid), 0);
    chk("R8 reset rdValid", 128'(rdValid), 0);
    @(negedge clk); rst = 1'b0;
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expNoRetire("R8 empty after reset");
  endtask

  task automatic testWriteThenNop();
    slot(WR, 1, 5'd3, 6'd10, pat(1), 16'h0000, 0, 0);
    expNoRetire("R1 first write");
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expRetire("R2 nop same", 5'd3, 6'd10, pat(1), 16'hFFFF);
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expNoRetire("R9 second nop");
  endtask

  task automatic testOtherDevice();
    slot(WR, 1, 5'd7, 6'd1, pat(2), 0, 0, 0);
    slot(RD, 0, 5'd7, 6'd1, 0, 0, 0, pat(50));
    expRetire("R3 read other", 5'd7, 6'd1, pat(2), 16'hFFFF);
    chk("R3 read other rdValid", 128'(rdValid), 0);
    slot(WR, 1, 5'd8, 6'd2, pat(3), 0, 0, 0);
    slot(WR, 0, 5'd9, 6'd3, pat(4), 0, 0, 0);
    expRetire("R3 write other", 5'd8, 6'd2, pat(3), 16'hFFFF);
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expNoRetire("R3 foreign write not loaded");
    slot(WR, 1, 5'd31, 6'd63, pat(5), 0, 0, 0);
    slot(NOP, 0, 0, 0, 0, 0, 0, 0);
    expRetire("R3 nop other", 5'd31, 6'd63, pat(5), 16'hFFFF);
  endtask

  task automatic testReadHold();
    slot(WR, 1, 5'd5, 6'd7, pat(6), 0, 0, 0);
    slot(RD, 1, 5'd5, 6'd7, 0, 0, 0, pat(60));
    expNoRetire("R4 read same hit");
    chk("R7 rdValid", 128'(rdValid), 1);
    chk("R7 full-mask merge", rdData, pat(6));
    slot(RD, 1, 5'd5, 6'd8, 0, 0, 0, pat(61));
    expNoRetire("R4 read same miss");
    chk("R7 miss gives core", rdData, pat(61));
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expRetire("R4 later retire", 5'd5, 6'd7, pat(6), 16'hFFFF);
    chk("R7 rdValid drops", 128'(rdValid), 0);
  endtask

  task automatic testMask();
    logic [127:0] exp;
    slot(WR, 1, 5'd12, 6'd33, pat(7), 16'h0F0F, 1, 0);
    slot(RD, 1, 5'd12, 6'd33, 0, 0, 0, pat(70));
    for (int b = 0; b < 16; b++)
      exp[b*8 +: 8] = ((16'h0F0F >> b) & 1) ? pat(7)>>(b*8) : pat(70)>>(b*8);
    chk("R7 partial-mask merge", rdData, exp);
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expRetire("R5 masked retire", 5'd12, 6'd33, pat(7), 16'h0F0F);
  endtask

  task automatic testBackToBack();
    slot(WR, 1, 5'd1, 6'd4, pat(8), 16'h00F0, 1, 0);
    slot(WR, 1, 5'd2, 6'd5, pat(9), 16'h1234, 0, 0);
    expRetire("R6 old retired", 5'd1, 6'd4, pat(8), 16'h00F0);
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expRetire("R6 new retired", 5'd2, 6'd5, pat(9), 16'hFFFF);
  endtask

  task automatic testIdleAndReset();
    slot(WR, 1, 5'd20, 6'd21, pat(10), 0, 0, 0);
    idle();
    expNoRetire("R10 idle 1");
    idle();
    expNoRetire("R10 idle 2");
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expRetire("R10 kept entry", 5'd20, 6'd21, pat(10), 16'hFFFF);
    slot(WR, 1, 5'd22, 6'd23, pat(11), 0, 0, 0);
    doReset();
    expNoRetire("R8 reset drop");
    slot(NOP, 1, 0, 0, 0, 0, 0, 0);
    expNoRetire("R8 nothing after reset");
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testWriteThenNop();
    testOtherDevice();
    testReadHold();
    testMask();
    testBackToBack();
    testIdleAndReset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule